// File: doc/BRIEF.md
# Masked Bulk Pin Configuration Writer

This block holds the per-pin configuration of one 32-pin I/O group. Each pin has four configuration flags (drive strength, pull enable, input enable, peripheral-mux enable) and a 4-bit peripheral-mux selection. Software updates them through a single write-only bulk port. One full 32-bit write copies the same flag values and the same mux selection into every pin chosen by a 16-bit mask in the lower or upper half of the group. Two separate enable bits in the word decide whether the flags, the mux selection, or both are updated.

The group's registers occupy a 0x80-byte window, and the bulk port sits at byte offset 0x28 in that window. An access classifier sorts each bus cycle into one of three named outcomes. ACC_IDLE means there is no write, or the write goes to another offset. ACC_IGNORED means a write to the bulk offset that is narrower than a word. ACC_APPLY means a full-word write to the bulk offset. Only ACC_APPLY produces per-pin select strobes. The classifier holds no state: every bus cycle is classified from scratch, and there are no transitions between outcomes.

When the access is flagged non-secure, a pin is updated only if its bit in the attribution vector marks it non-secure. Other pins are skipped without any error. Reads of the bulk port return zero. The per-pin registers are the block's only storage.

Top module: `pincfg_bulk_writer`

## Requirements
- R1: After reset, every pin's four configuration flags and its 4-bit mux selection are zero, and `rd_data` is zero.
- R2: The write word is decoded as follows: bit 31 is the half select, bit 30 the flag-write enable, bit 28 the mux-write enable, bits 27:24 the mux value, bit 22 drive strength, bit 18 pull enable, bit 17 input enable, bit 16 mux enable, and bits 15:0 the pin mask. A full-word write (`bus_size` = 2'b10) to offset 0x28 with bit 30 set and bit 31 clear loads the four flags into pin i for every set mask bit i.
- R3: With bit 31 set, mask bit i selects pin i+16 instead, and no pin in the lower half changes.
- R4: A pin whose mask bit is clear keeps all of its flags and its mux selection.
- R5: When bit 30 is clear, no configuration flag of any pin changes.
- R6: When bit 28 is set, each selected pin's mux selection is loaded from bits 27:24. When bit 28 is clear, no mux selection changes.
- R7: When bits 30 and 28 are both set, flags and mux selections of all selected pins update together on the same clock edge.
- R8: A write with `bus_size` 2'b00 (byte), 2'b01 (half-word) or 2'b11 (reserved) changes nothing.
- R9: For a write with `bus_nonsec` = 1, only pins whose `pin_nonsec` bit is 1 are updated. With `bus_nonsec` = 0, the attribution vector has no effect.
- R10: Writes to any offset other than 0x28 change nothing, and `rd_data` is always zero.
- R11: A write takes effect on the rising edge at which `bus_we` is sampled. The outputs still show the old values before that edge and the new values right after it, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte offset within the group's 0x80 window |
| bus_wdata | input | 32 | Write word |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word, 11 reserved |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_nonsec | input | 1 | Access is non-secure |
| pin_nonsec | input | 32 | Per-pin attribution, 1 = non-secure |
| rd_data | output | 32 | Read data of the bulk port (always zero) |
| cfg_drive | output | 32 | Per-pin drive-strength flag |
| cfg_pull | output | 32 | Per-pin pull-enable flag |
| cfg_inen | output | 32 | Per-pin input-enable flag |
| cfg_muxen | output | 32 | Per-pin peripheral-mux enable flag |
| cfg_musel | output | 128 | Per-pin mux selection, pin p at bits 4p+3:4p |

## Verification
The bench sweeps both half selects, all four enable combinations, both security flags, every access size and a range of masks and attribution vectors. After each write it compares every pin against an arithmetic model. Several mistakes are targeted. A design that ignores the half select would corrupt the opposite half. One that ties the mux update to the flag enable would change mux fields on flag-only writes. One that decodes the size loosely would let byte or half-word writes through. One that skips the security filter would overwrite secure pins on non-secure writes. Pre-edge samples also catch an update that arrives a cycle early through a combinational path, and writes to neighbouring offsets catch a partial address decode.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } bus_size_e;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_IGNORED = 2'd1,
        ACC_APPLY   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic drive;
        logic pull;
        logic inen;
        logic muxen;
    } pin_cfg_t;

    localparam int HALF_SEL_BIT = 31;
    localparam int CFG_WE_BIT   = 30;
    localparam int MUX_WE_BIT   = 28;
    localparam int MUX_LSB      = 24;
    localparam int DRIVE_BIT    = 22;
    localparam int PULL_BIT     = 18;
    localparam int INEN_BIT     = 17;
    localparam int MUXEN_BIT    = 16;

endpackage

// File: rtl/pcw_access_decode.sv
module pcw_access_decode
    import pcw_pkg::*;
#(
    parameter int PINS     = 32,
    parameter int MUX_W    = 4,
    parameter int ADDR_W   = 7,
    parameter int BULK_OFF = 'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic              bus_nonsec,
    input  logic [PINS-1:0]   pin_nonsec,
    output logic [PINS-1:0]   pin_sel,
    output logic              cfg_we,
    output logic              mux_we,
    output pin_cfg_t          cfg_val,
    output logic [MUX_W-1:0]  mux_val
);

    localparam int MASK_W = PINS / 2;

    acc_kind_e kind;
    logic      half_sel;
    logic      apply;
    logic      unused_wdata;

    assign unused_wdata = ^{bus_wdata[29], bus_wdata[23:19]};

    always_comb begin
        if (!bus_we || (bus_addr != ADDR_W'(BULK_OFF))) begin
            kind = ACC_IDLE;
        end else if (bus_size_e'(bus_size) != SZ_WORD) begin
            kind = ACC_IGNORED;
        end else begin
            kind = ACC_APPLY;
        end
    end

    always_comb begin
        unique case (kind)
            ACC_APPLY: begin
                apply  = 1'b1;
                cfg_we = bus_wdata[CFG_WE_BIT];
                mux_we = bus_wdata[MUX_WE_BIT];
            end
            ACC_IGNORED, ACC_IDLE: begin
                apply  = 1'b0;
                cfg_we = 1'b0;
                mux_we = 1'b0;
            end
            default: begin
                apply  = 1'b0;
                cfg_we = 1'b0;
                mux_we = 1'b0;
            end
        endcase
    end

    assign half_sel      = bus_wdata[HALF_SEL_BIT];
    assign mux_val       = bus_wdata[MUX_LSB +: MUX_W];
    assign cfg_val.drive = bus_wdata[DRIVE_BIT];
    assign cfg_val.pull  = bus_wdata[PULL_BIT];
    assign cfg_val.inen  = bus_wdata[INEN_BIT];
    assign cfg_val.muxen = bus_wdata[MUXEN_BIT];

    for (genvar p = 0; p < PINS; p++) begin : g_sel
        localparam logic UPPER = (p >= MASK_W);
        assign pin_sel[p] = apply
                          && bus_wdata[p % MASK_W]
                          && (half_sel == UPPER)
                          && (!bus_nonsec || pin_nonsec[p]);
    end

    // R8: narrow or reserved-size writes raise no select strobe
    p_subword_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_size != 2'b10) |-> (pin_sel == '0));

    // R9: a non-secure access never selects a secure-attributed pin
    p_secure_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_nonsec |-> ((pin_sel & ~pin_nonsec) == '0));

    // R3: selection never spans both halves of the group
    p_one_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel[MASK_W-1:0] != '0) |-> (pin_sel[PINS-1:MASK_W] == '0));

    // R10: other offsets raise no select strobe
    p_offset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(BULK_OFF)) |-> (pin_sel == '0));

endmodule

// File: rtl/pcw_pin_cell.sv
module pcw_pin_cell
    import pcw_pkg::*;
#(
    parameter int MUX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             cfg_we,
    input  logic             mux_we,
    input  pin_cfg_t         cfg_val,
    input  logic [MUX_W-1:0] mux_val,
    output pin_cfg_t         cfg_q,
    output logic [MUX_W-1:0] mux_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            mux_q <= '0;
        end else begin
            if (sel && cfg_we) cfg_q <= cfg_val;
            if (sel && mux_we) mux_q <= mux_val;
        end
    end

    // R2: a selected flag write lands on the next edge
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_we) |=> (cfg_q == $past(cfg_val)));

    // R5: without a selected flag write the flags hold
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && cfg_we) |=> $stable(cfg_q));

    // R6: mux selection loads only on a selected mux write
    p_mux_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mux_we) |=> (mux_q == $past(mux_val)));

    p_mux_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && mux_we) |=> $stable(mux_q));

endmodule

// File: rtl/pincfg_bulk_writer.sv
module pincfg_bulk_writer
    import pcw_pkg::*;
#(
    parameter int PINS     = 32,
    parameter int MUX_W    = 4,
    parameter int ADDR_W   = 7,
    parameter int BULK_OFF = 'h28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [1:0]            bus_size,
    input  logic                  bus_we,
    input  logic                  bus_nonsec,
    input  logic [PINS-1:0]       pin_nonsec,
    output logic [31:0]           rd_data,
    output logic [PINS-1:0]       cfg_drive,
    output logic [PINS-1:0]       cfg_pull,
    output logic [PINS-1:0]       cfg_inen,
    output logic [PINS-1:0]       cfg_muxen,
    output logic [PINS*MUX_W-1:0] cfg_musel
);

    logic [PINS-1:0]  pin_sel;
    logic             cfg_we;
    logic             mux_we;
    pin_cfg_t         cfg_val;
    logic [MUX_W-1:0] mux_val;

    pcw_access_decode #(
        .PINS(PINS), .MUX_W(MUX_W), .ADDR_W(ADDR_W), .BULK_OFF(BULK_OFF)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_size   (bus_size),
        .bus_we     (bus_we),
        .bus_nonsec (bus_nonsec),
        .pin_nonsec (pin_nonsec),
        .pin_sel    (pin_sel),
        .cfg_we     (cfg_we),
        .mux_we     (mux_we),
        .cfg_val    (cfg_val),
        .mux_val    (mux_val)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_cfg_t cq;
        pcw_pin_cell #(.MUX_W(MUX_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (pin_sel[p]),
            .cfg_we  (cfg_we),
            .mux_we  (mux_we),
            .cfg_val (cfg_val),
            .mux_val (mux_val),
            .cfg_q   (cq),
            .mux_q   (cfg_musel[p*MUX_W +: MUX_W])
        );
        assign cfg_drive[p] = cq.drive;
        assign cfg_pull[p]  = cq.pull;
        assign cfg_inen[p]  = cq.inen;
        assign cfg_muxen[p] = cq.muxen;
    end

    // R10: the bulk port is write-only; reads return zero
    assign rd_data = '0;

    // R7: with both enables, flags and mux of a selected pin move on one edge
    p_joint_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel[0] && cfg_we && mux_we) |=>
            ({cfg_drive[0], cfg_pull[0], cfg_inen[0], cfg_muxen[0], cfg_musel[MUX_W-1:0]}
             == {$past(cfg_val), $past(mux_val)}));

endmodule

// File: tb/sim_pincfg_bulk_writer.sv
module sim_pincfg_bulk_writer;

    localparam int PINS  = 32;
    localparam int MUX_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [6:0]            bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic [1:0]            bus_size = '0;
    logic                  bus_we = 1'b0;
    logic                  bus_nonsec = 1'b0;
    logic [PINS-1:0]       pin_nonsec = '0;
    logic [31:0]           rd_data;
    logic [PINS-1:0]       cfg_drive, cfg_pull, cfg_inen, cfg_muxen;
    logic [PINS*MUX_W-1:0] cfg_musel;

    always #2 clk = ~clk;

    pincfg_bulk_writer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_we(bus_we), .bus_nonsec(bus_nonsec),
        .pin_nonsec(pin_nonsec), .rd_data(rd_data), .cfg_drive(cfg_drive),
        .cfg_pull(cfg_pull), .cfg_inen(cfg_inen), .cfg_muxen(cfg_muxen),
        .cfg_musel(cfg_musel)
    );

    int checks = 0;
    int errors = 0;
    logic [3:0] m_cfg [PINS];
    logic [3:0] m_mux [PINS];

    function automatic logic [31:0] mkword(bit hw, bit cwe, bit mwe, logic [3:0] mx,
                                           logic [3:0] flags, logic [15:0] mask);
        logic [31:0] w = '0;
        w[31] = hw; w[30] = cwe; w[28] = mwe; w[27:24] = mx;
        w[22] = flags[3]; w[18] = flags[2]; w[17] = flags[1]; w[16] = flags[0];
        w[15:0] = mask;
        return w;
    endfunction

    task automatic model_apply(logic [6:0] a, logic [31:0] d, logic [1:0] sz, bit ns);
        if (a == 7'h28 && sz == 2'b10) begin
            for (int p = 0; p < PINS; p++) begin
                if (d[p % 16] && (d[31] == (p >= 16)) && (!ns || pin_nonsec[p])) begin
                    if (d[30]) m_cfg[p] = {d[22], d[18], d[17], d[16]};
                    if (d[28]) m_mux[p] = d[27:24];
                end
            end
        end
    endtask

    task automatic check_state(string tag);
        logic [PINS-1:0] ed, ep, ei, em;
        logic [PINS*MUX_W-1:0] ex;
        for (int p = 0; p < PINS; p++) begin
            ed[p] = m_cfg[p][3]; ep[p] = m_cfg[p][2];
            ei[p] = m_cfg[p][1]; em[p] = m_cfg[p][0];
            ex[p*MUX_W +: MUX_W] = m_mux[p];
        end
        checks++;
        if ({cfg_drive, cfg_pull, cfg_inen, cfg_muxen} !== {ed, ep, ei, em}) begin
            errors++;
            $display("FAIL %s flags: actual=%h_%h_%h_%h expected=%h_%h_%h_%h", tag,
                     cfg_drive, cfg_pull, cfg_inen, cfg_muxen, ed, ep, ei, em);
        end
        checks++;
        if (cfg_musel !== ex) begin
            errors++;
            $display("FAIL %s mux: actual=%h expected=%h", tag, cfg_musel, ex);
        end
        checks++;
        if (rd_data !== 32'h0) begin
            errors++;
            $display("FAIL R10 rd_data: actual=%h expected=0", rd_data);
        end
    endtask

    // drive on a falling edge, optionally verify pre-edge outputs, then sample after the edge
    task automatic bus_write(logic [6:0] a, logic [31:0] d, logic [1:0] sz, bit ns,
                             string tag, bit pre_check);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_nonsec = ns; bus_we = 1'b1;
        #1;
        if (pre_check) check_state("R11 pre-edge");
        @(negedge clk);
        bus_we = 1'b0;
        model_apply(a, d, sz, ns);
        check_state(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < PINS; p++) begin m_cfg[p] = '0; m_mux[p] = '0; end
        repeat (3) @(negedge clk);
        check_state("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after release");

        // R2: lower half, all mask bits, flags only
        bus_write(7'h28, mkword(0, 1, 0, 4'h9, 4'b1011, 16'hFFFF), 2'b10, 0, "R2 lower all", 1);
        // R3: upper half
        bus_write(7'h28, mkword(1, 1, 0, 4'h3, 4'b0110, 16'h00F1), 2'b10, 0, "R3 upper", 1);
        // R4: sparse mask leaves others unchanged
        bus_write(7'h28, mkword(0, 1, 0, 4'h0, 4'b0000, 16'h8421), 2'b10, 0, "R4 sparse", 0);
        // R5: flag enable clear
        bus_write(7'h28, mkword(0, 0, 0, 4'hF, 4'b1111, 16'hFFFF), 2'b10, 0, "R5 no flag", 0);
        // R6: mux only
        bus_write(7'h28, mkword(1, 0, 1, 4'hA, 4'b1111, 16'h0F0F), 2'b10, 0, "R6 mux only", 1);
        // R7: both enables together
        bus_write(7'h28, mkword(0, 1, 1, 4'h5, 4'b1100, 16'h3C3C), 2'b10, 0, "R7 both", 1);
        // R8: byte, half-word and reserved sizes
        bus_write(7'h28, mkword(0, 1, 1, 4'hE, 4'b1111, 16'hFFFF), 2'b00, 0, "R8 byte", 0);
        bus_write(7'h28, mkword(1, 1, 1, 4'hE, 4'b1111, 16'hFFFF), 2'b01, 0, "R8 half", 0);
        bus_write(7'h28, mkword(1, 1, 1, 4'hE, 4'b1111, 16'hFFFF), 2'b11, 0, "R8 rsvd", 0);
        // R9: non-secure filtered, secure unaffected by attribution
        pin_nonsec = 32'h00FF_0F0F;
        bus_write(7'h28, mkword(0, 1, 1, 4'h7, 4'b0101, 16'hFFFF), 2'b10, 1, "R9 nonsec low", 1);
        bus_write(7'h28, mkword(1, 1, 1, 4'hC, 4'b1010, 16'hFFFF), 2'b10, 1, "R9 nonsec high", 0);
        bus_write(7'h28, mkword(1, 1, 1, 4'h2, 4'b0011, 16'hFFFF), 2'b10, 0, "R9 secure", 0);
        // R10: neighbouring offsets
        bus_write(7'h24, mkword(0, 1, 1, 4'hB, 4'b1111, 16'hFFFF), 2'b10, 0, "R10 off 24", 0);
        bus_write(7'h2C, mkword(0, 1, 1, 4'hB, 4'b1111, 16'hFFFF), 2'b10, 0, "R10 off 2C", 0);
        bus_write(7'h68, mkword(1, 1, 1, 4'hB, 4'b1111, 16'hFFFF), 2'b10, 0, "R10 off 68", 0);

        // sweep: half x enables x security x size x mask patterns
        begin
            int iter = 0;
            for (int hw = 0; hw < 2; hw++)
            for (int en = 0; en < 4; en++)
            for (int ns = 0; ns < 2; ns++)
            for (int sz = 0; sz < 4; sz++)
            for (int k = 0; k < 4; k++) begin
                logic [15:0] mask;
                logic [31:0] d;
                string tag;
                iter++;
                mask = 16'(32'hA5C3 * (k + 1) + iter * 7);
                pin_nonsec = 32'h0F0F_33CC ^ (iter * 32'h9E37_79B9);
                d = mkword(hw[0], en[1], en[0], 4'(iter * 3), 4'(iter * 5 + 1), mask);
                if (sz != 2) tag = "R8 sweep";
                else if (ns != 0) tag = "R9 sweep";
                else if (en == 3) tag = "R7 sweep";
                else if (en == 1) tag = "R6 sweep";
                else if (en == 0) tag = "R5 sweep";
                else tag = hw ? "R3 sweep" : "R2 sweep";
                bus_write(7'h28, d, 2'(sz), ns[0], tag, (k == 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule